// File: doc/BRIEF.md
# Serial EEPROM Station Identifier Fetcher

This block pulls a six-byte station identifier out of a three-wire serial EEPROM. A single start pulse makes it run three read transactions back to back, one for each of the word addresses 2, 3 and 4. For each transaction it drives the chip-select, serial-clock and data-in pins, and it samples the data-out pin. Each received word is stored in the identifier register. When all three words are in place, a one-cycle done pulse is given.

Every level of the serial clock is timed by a prescaler that counts `HALF_DIV` system clocks. At the default of 250 and a 50 MHz system clock, one half-period lasts about 5 µs. A transaction runs in this order:
- one half-period with all pins low;
- the read command, three bits;
- a six-bit word address, most significant bit first;
- sixteen data clocks;
- a closing half-period with the pins low.

The bits of each received word are packed so that the first bit to arrive lands in bit 0.

Top module: `eeprom_id_fetch`

## Requirements
- R1: While `rst` is high (synchronous, active high), `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are 0 and `id_bytes` is cleared to zero.
- R2: Each transaction opens with `ee_cs`, `ee_sk` and `ee_di` all low for at least one half-period. `ee_cs` then rises together with `ee_di`=1 while `ee_sk` is low. The first three bits clocked in are the read command 1, 1, 0.
- R3: `ee_di` changes only while `ee_sk` is low, and it holds its value for the whole of every high phase of `ee_sk`.
- R4: After the command, six address bits are clocked out MSB first. Transaction k (k = 0, 1, 2) carries word address 2 + k.
- R5: During the sixteen data clocks `ee_di` is 0. `ee_do` is sampled at the end of each high phase of `ee_sk`.
- R6: Received bits are packed LSB first: before each sample the word shifts right and the new bit enters bit 15, so the first bit received ends in bit 0.
- R7: `ee_sk` is high only while `ee_cs` is high. Each transaction ends with `ee_sk` and `ee_cs` low, and all three outputs stay low whenever `busy` is 0.
- R8: Identifier byte n sits at `id_bytes[8n+7:8n]`. Byte 2k is the low byte and byte 2k+1 the high byte of the word read in transaction k.
- R9: Every high phase of `ee_sk` lasts exactly `HALF_DIV` system clocks, and no level of `ee_sk` lasts fewer.
- R10: `done` is high for exactly one cycle, in the cycle `busy` falls, and `id_bytes` then holds all six bytes. `busy` falls only together with `done`.
- R11: A `start` pulse while `busy` is 1 is ignored: exactly three transactions and one `done` pulse follow the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to fetch the identifier |
| busy | output | 1 | High from accepted start until done |
| done | output | 1 | One-cycle pulse when the identifier is complete |
| id_bytes | output | 48 | Six identifier bytes, byte n at bits 8n+7..8n |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The assertions check the pin protocol on every cycle:
- `ee_di` stays steady through every high phase of `ee_sk`;
- the serial clock never runs outside chip select;
- chip select opens with data-in high;
- no clock level is shorter than the programmed half-period;
- the pins are quiet when the block is idle;
- the done pulse is one cycle long and matches the fall of busy.

Only the bench scenarios can show the rest, because each needs a model of the EEPROM's side of the exchange:
- the command and address values that actually reach the EEPROM;
- the reversed bit packing of the returned words;
- the low-byte-first placement of the three words;
- that a second start during a fetch adds no transaction.

// File: rtl/eeprom_id_pkg.sv
package eeprom_id_pkg;
  localparam int OPC_W   = 3;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = OPC_W + ADDR_W;

  localparam logic [OPC_W-1:0] READ_OPC = 3'b110;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [1:0] {RD_IDLE, RD_PRE, RD_SHIFT, RD_END} rd_state_t;

  // Command followed by address, first bit on the wire in the MSB.
  function automatic frame_t make_frame(input addr_t a);
    return {READ_OPC, a};
  endfunction

  // Bit sent in serial slot idx; zero once the frame is exhausted.
  function automatic logic frame_bit(input frame_t f, input int idx);
    if (idx < FRAME_W) return f[FRAME_W-1-idx];
    return 1'b0;
  endfunction

  // Right shift with the incoming bit entering at the top.
  function automatic word_t shift_in_lsb(input word_t w, input logic b);
    return {b, w[DATA_W-1:1]};
  endfunction

  // Low byte into the earlier (lower) lane, high byte into the next one.
  function automatic word_t place_bytes(input word_t w);
    return {w[15:8], w[7:0]};
  endfunction
endpackage

// File: rtl/uwire_halfclk.sv
module uwire_halfclk #(
  parameter int HALF_DIV = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/uwire_word_read.sv
module uwire_word_read
  import eeprom_id_pkg::*;
#(
  parameter int HALF_DIV = 250
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  input  addr_t addr,
  input  logic  do_in,
  output logic  cs,
  output logic  sk,
  output logic  di,
  output logic  word_done,
  output word_t word
);
  localparam int SLOTS  = FRAME_W + DATA_W;
  localparam int SLOT_W = $clog2(SLOTS);

  rd_state_t         st;
  logic              hi;
  logic [SLOT_W-1:0] slot;
  frame_t            frame;
  logic              tick;
  logic              running;

  assign running = (st != RD_IDLE);

  uwire_halfclk #(.HALF_DIV(HALF_DIV)) u_half (
    .clk  (clk),
    .rst  (rst),
    .run  (running),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RD_IDLE;
      hi        <= 1'b0;
      slot      <= '0;
      frame     <= '0;
      cs        <= 1'b0;
      sk        <= 1'b0;
      di        <= 1'b0;
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      word_done <= 1'b0;
      case (st)
        RD_IDLE: if (go) begin
          st    <= RD_PRE;
          frame <= make_frame(addr);
          slot  <= '0;
          hi    <= 1'b0;
          word  <= '0;
          cs    <= 1'b0;
          sk    <= 1'b0;
          di    <= 1'b0;
        end
        RD_PRE: if (tick) begin
          st <= RD_SHIFT;
          cs <= 1'b1;
          di <= frame_bit(frame, 0);
        end
        RD_SHIFT: if (tick) begin
          if (!hi) begin
            hi <= 1'b1;
            sk <= 1'b1;
          end else begin
            hi <= 1'b0;
            sk <= 1'b0;
            if (int'(slot) >= FRAME_W) word <= shift_in_lsb(word, do_in);
            if (int'(slot) == SLOTS - 1) begin
              st <= RD_END;
              cs <= 1'b0;
              di <= 1'b0;
            end else begin
              slot <= slot + 1'b1;
              di   <= frame_bit(frame, int'(slot) + 1);
            end
          end
        end
        RD_END: if (tick) begin
          st        <= RD_IDLE;
          word_done <= 1'b1;
        end
        default: st <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_id_fetch.sv
module eeprom_id_fetch
  import eeprom_id_pkg::*;
#(
  parameter int HALF_DIV   = 250,
  parameter int FIRST_WORD = 2,
  parameter int NUM_WORDS  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic [NUM_WORDS*16-1:0]  id_bytes,
  output logic                     ee_cs,
  output logic                     ee_sk,
  output logic                     ee_di,
  input  logic                     ee_do
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [IDX_W-1:0] idx;
  logic             launch;
  logic             word_done;
  word_t            word;
  addr_t            rd_addr;

  assign rd_addr = addr_t'(FIRST_WORD) + addr_t'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      launch <= 1'b0;
      idx    <= '0;
    end else begin
      launch <= 1'b0;
      done   <= 1'b0;
      if (!busy && start) begin
        busy   <= 1'b1;
        idx    <= '0;
        launch <= 1'b1;
      end else if (busy && word_done) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx    <= idx + 1'b1;
          launch <= 1'b1;
        end
      end
    end
  end

  uwire_word_read #(.HALF_DIV(HALF_DIV)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .go        (launch),
    .addr      (rd_addr),
    .do_in     (ee_do),
    .cs        (ee_cs),
    .sk        (ee_sk),
    .di        (ee_di),
    .word_done (word_done),
    .word      (word)
  );

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    word_t held;
    always_ff @(posedge clk) begin
      if (rst)                                     held <= '0;
      else if (word_done && idx == IDX_W'(g))      held <= word;
    end
    assign id_bytes[g*16 +: 16] = place_bytes(held);
  end
endmodule

// File: rtl/eeprom_id_fetch_checker.sv
module eeprom_id_fetch_checker #(
  parameter int HALF_DIV = 250
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic word_done,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  localparam int RUN_W = $clog2(HALF_DIV + 1) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HALF_DIV);

  logic [RUN_W-1:0] run_q;
  logic             sk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      sk_d  <= 1'b0;
    end else begin
      sk_d <= ee_sk;
      if (ee_sk != sk_d) begin
        assert_half_period_R9: assert (run_q >= RUN_MAX)
          else $error("serial clock level shorter than half-period");
        run_q <= RUN_W'(1);
      end else if (run_q < RUN_MAX) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_cs_opens_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> (ee_di && !ee_sk));

  assert_di_steady_R3: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> $stable(ee_di));

  assert_sk_in_cs_R7: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs);

  assert_cs_closes_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_cs) |-> !ee_sk);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(ee_cs || ee_sk || ee_di));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_ends_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_after_word_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(word_done));

  assert_start_taken_R11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

bind eeprom_id_fetch eeprom_id_fetch_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .word_done (word_done),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_di     (ee_di)
);

// File: tb/eeprom_id_fetch_bench.sv
module eeprom_id_fetch_bench;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done;
  logic [47:0] id_bytes;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seed   = 0;

  always #10 clk = ~clk;

  eeprom_id_fetch #(.HALF_DIV(H)) u_eeprom_id_fetch (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .id_bytes(id_bytes), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  function automatic logic [15:0] mem_word(input int s, input int a);
    case (s)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return (a % 2 == 1) ? 16'h5AA5 : 16'h8001;
      default: return 16'((a * 40503 + s * 4099) ^ 16'h2C71);
    endcase
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[15 - i];
    return r;
  endfunction

  // EEPROM model: captures 9 frame bits, then returns the stored word MSB first.
  int         bitn = 0;
  logic [7:0] cmd_sh = '0;
  int         cur_addr = 0;
  int         trans_cnt = 0;
  logic [2:0] op_log [64];
  int         addr_log [64];
  int         di_bad = 0, width_bad = 0, cs_bad = 0;
  int         hw = 0;
  logic       sk_prev = 1'b0, di_prev = 1'b0, cs_prev = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sk_prev <= ee_sk;
    di_prev <= ee_di;
    cs_prev <= ee_cs;
    if (ee_sk && sk_prev && ee_di != di_prev) di_bad <= di_bad + 1;
    if (ee_cs && !cs_prev && (!ee_di || ee_sk)) cs_bad <= cs_bad + 1;
    if (ee_sk) hw <= hw + 1;
    else begin
      if (sk_prev && hw != H) width_bad <= width_bad + 1;
      hw <= 0;
    end
    if (!ee_cs) begin
      bitn  <= 0;
      ee_do <= 1'b0;
    end else if (ee_sk && !sk_prev) begin
      bitn <= bitn + 1;
      if (bitn < 8) cmd_sh <= {cmd_sh[6:0], ee_di};
      else if (bitn == 8) begin
        op_log[trans_cnt % 64]   <= cmd_sh[7:5];
        addr_log[trans_cnt % 64] <= int'({cmd_sh[4:0], ee_di});
        cur_addr  <= int'({cmd_sh[4:0], ee_di});
        trans_cnt <= trans_cnt + 1;
      end else begin
        if (ee_di) di_bad <= di_bad + 1;
        ee_do <= mem_word(seed, cur_addr)[24 - bitn];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_fetch(input int s, input bit extra_start);
    int base, dbad0, wbad0, cbad0, lead, ncyc, dones;
    logic [47:0] exp;
    bit seen_cs;
    seed  = s;
    @(negedge clk);
    base  = trans_cnt; dbad0 = di_bad; wbad0 = width_bad; cbad0 = cs_bad;
    start = 1'b1;
    lead = 0; seen_cs = 0; dones = 0; ncyc = 0;
    while (ncyc < 20000) begin
      @(negedge clk);
      ncyc++;
      start = (extra_start && ncyc == 150);
      if (!seen_cs) begin
        if (ee_cs) seen_cs = 1; else lead++;
      end
      if (done) begin dones++; break; end
    end
    start = 1'b0;
    chk(dones == 1, "R10 done seen", 64'(dones), 64'd1);
    chk(busy == 1'b0, "R10 busy low at done", 64'(busy), 64'd0);
    chk(lead >= H, "R2 low lead-in", 64'(lead), 64'(H));
    for (int k = 0; k < 3; k++) begin
      exp[k*16 +: 8]     = rev16(mem_word(s, 2 + k))[7:0];
      exp[k*16 + 8 +: 8] = rev16(mem_word(s, 2 + k))[15:8];
    end
    chk(id_bytes == exp, "R6 R8 identifier", 64'(id_bytes), 64'(exp));
    chk(trans_cnt - base == 3, "R11 transaction count", 64'(trans_cnt - base), 64'd3);
    for (int k = 0; k < 3; k++) begin
      chk(op_log[(base + k) % 64] == 3'b110, "R2 read command",
          64'(op_log[(base + k) % 64]), 64'h6);
      chk(addr_log[(base + k) % 64] == 2 + k, "R4 word address",
          64'(addr_log[(base + k) % 64]), 64'(2 + k));
    end
    chk(di_bad == dbad0, "R3 R5 data-in discipline", 64'(di_bad - dbad0), 64'd0);
    chk(width_bad == wbad0, "R9 high phase width", 64'(width_bad - wbad0), 64'd0);
    chk(cs_bad == cbad0, "R2 cs opening", 64'(cs_bad - cbad0), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R7 pins low after fetch",
        64'({ee_cs, ee_sk, ee_di}), 64'd0);
    if (extra_start) begin
      repeat (4 * H) @(negedge clk);
      chk(busy == 1'b0 && trans_cnt - base == 3, "R11 no restart from ignored start",
          64'(trans_cnt - base), 64'd3);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins in reset",
        64'({ee_cs, ee_sk, ee_di}), 64'd0);
    chk({busy, done} == 2'b00, "R1 handshake in reset", 64'({busy, done}), 64'd0);
    chk(id_bytes == 48'd0, "R1 identifier cleared", 64'(id_bytes), 64'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, ee_cs} == 2'b00, "R7 idle without start", 64'({busy, ee_cs}), 64'd0);
    for (int s = 0; s < 7; s++) run_fetch(s, s == 3);
    run_fetch(5, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule